// File: doc/BRIEF.md
# Pin Pull-Resistor Programming Sequencer

This block holds the pull-resistor setting of every pin of a GPIO array and lets software change it only through a timed two-step handshake. Software first writes a 2-bit pull mode into a control register. It then waits for a setup interval and sets the bits of the pins to program in a per-bank clock register. A pin takes the pending mode when its clock bit goes from 0 to 1, but only if enough cycles have passed since the last control write. A clock pulse that comes too early is dropped.

The applied pull settings go out on a flat per-pin bus to the pad ring and cannot be read back over the register bus. Only the control and clock registers can be read, and they return what was last written. To program several pins with different modes, software repeats the sequence once per mode. Pins that share a mode can be pulsed in the same clock write.

Top module: `pin_pull_sequencer`

## Requirements
- R1: After reset every pin's pull output equals the RESET_PULL parameter, and the control register and all clock registers read as zero.
- R2: The control register sits at byte address 0x94. It stores write-data bits [1:0], which encode the mode as 0 = off, 1 = pull-down, 2 = pull-up and 3 = reserved. A read returns the stored value in bits [1:0] with all upper bits zero.
- R3: Clock register b sits at byte address 0x98 + 4*b, and its bit i belongs to pin 32*b + i. A read returns the last written value, with bits for pins at or above NUM_PINS reading zero.
- R4: A pin's pull output takes the control value when its clock bit goes from 0 to 1 in a write made at least SETUP_CYCLES clock edges after the last control write. The new value is visible after that write's clock edge.
- R5: A clock bit that goes from 0 to 1 fewer than SETUP_CYCLES edges after the last control write leaves the pin unchanged. Holding that bit high afterwards never latches it.
- R6: Every control write restarts the setup interval, even when it writes the same value again.
- R7: Latching while the control value is the reserved code 3 gives the pin the off code 0.
- R8: One clock write latches every pin whose bit rises. Pins whose bit was already high or stays low keep their state.
- R9: A clock bit going from 1 to 0, and reads at any address other than the control and clock registers, leave pull outputs unchanged. Reads at those other addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pull_state | output | 2*NUM_PINS | Pull mode of pin p on bits [2p+1:2p] |

## Verification
On every cycle, the assertions check three things. First, a pin's state changes only when the setup timer had expired and that pin's clock bit rose. Second, a control write restarts the timer and the timer never passes its limit. Third, a latched state is never the reserved code, clock registers hold without a write, and unmapped reads return zero. The setup boundary itself needs the bench's scenarios: accepted at exactly SETUP_CYCLES edges and rejected one edge earlier. So do the restart by a repeated write of the same value, the hidden state under a bit held high, and the readback values. The bench compares all of these against its own model of the handshake.

// File: rtl/pull_pkg.sv
package pull_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DN   = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_mode_e;

  localparam int BUS_W  = 32;
  localparam int LANE_W = 32;

  // Reserved code collapses to "off" when applied to a pin.
  function automatic logic [1:0] pull_effective(input logic [1:0] mode);
    return (mode == PULL_RSVD) ? PULL_NONE : mode;
  endfunction

endpackage

// File: rtl/pull_setup_timer.sv
module pull_setup_timer #(
  parameter int SETUP_CYCLES = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)          cnt_d = CW'(1);
    else if (cnt_q != LIMIT) cnt_d = cnt_q + CW'(1);
  end

  // Timer starts expired so a pin can be programmed to "off" straight after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIMIT;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LIMIT);

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == CW'(1)));
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/pull_clk_bank.sv
module pull_clk_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] bits_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    rise_o = '0;
    if (wr_i) begin
      bits_d = wdata_i;
      rise_o = wdata_i & ~bits_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(bits_q));

endmodule

// File: rtl/pull_state_array.sv
module pull_state_array
  import pull_pkg::*;
#(
  parameter int         NUM_PINS   = 54,
  parameter logic [1:0] RESET_PULL = 2'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   rise_i,
  input  logic                  ready_i,
  input  logic [1:0]            mode_i,
  output logic [2*NUM_PINS-1:0] state_o
);
  logic [1:0] state_q [NUM_PINS];
  logic [1:0] state_d [NUM_PINS];
  logic [1:0] applied;

  assign applied = pull_effective(mode_i);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      state_d[p] = state_q[p];
      if (rise_i[p] && ready_i) state_d[p] = applied;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q[p] <= RESET_PULL;
      else        state_q[p] <= state_d[p];
    end

    assign state_o[2*p +: 2] = state_q[p];

    a_r5_early_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> $stable(state_q[p]));
    a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_i[p] |=> $stable(state_q[p]));
    a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i[p] && ready_i) |=> (state_q[p] != 2'b11));
  end

endmodule

// File: rtl/pin_pull_sequencer.sv
module pin_pull_sequencer
  import pull_pkg::*;
#(
  parameter int         NUM_PINS     = 54,
  parameter int         SETUP_CYCLES = 150,
  parameter int         ADDR_W       = 8,
  parameter logic [1:0] RESET_PULL   = 2'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic [2*NUM_PINS-1:0] pull_state
);
  localparam int NUM_BANKS = (NUM_PINS + LANE_W - 1) / LANE_W;
  localparam int CTRL_OFFS = 'h94;
  localparam int CLK_OFFS  = 'h98;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Control register
  logic       ctrl_hit, ctrl_wr;
  logic [1:0] ctrl_q, ctrl_d;
  logic       setup_ready;

  assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_OFFS));
  assign ctrl_wr  = bus_wr && ctrl_hit;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= PULL_NONE;
    else            ctrl_q <= ctrl_d;
  end

  pull_setup_timer #(.SETUP_CYCLES(SETUP_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart_i (ctrl_wr),
    .ready_o   (setup_ready)
  );

  // Per-bank clock registers
  logic [NUM_PINS-1:0] rise_all;
  logic [BUS_W-1:0]    bank_word [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = ((NUM_PINS - LANE_W*b) > LANE_W) ? LANE_W : (NUM_PINS - LANE_W*b);
    logic [BW-1:0] bits;
    logic [BW-1:0] rise;

    assign bank_hit[b] = (bus_addr == ADDR_W'(CLK_OFFS + 4*b));

    pull_clk_bank #(.WIDTH(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_i    (bus_wr && bank_hit[b]),
      .wdata_i (bus_wdata[BW-1:0]),
      .bits_o  (bits),
      .rise_o  (rise)
    );

    assign rise_all[LANE_W*b +: BW] = rise;

    if (BW == BUS_W) begin : g_full
      assign bank_word[b] = bits;
    end else begin : g_part
      assign bank_word[b] = {{(BUS_W-BW){1'b0}}, bits};
    end
  end

  pull_state_array #(.NUM_PINS(NUM_PINS), .RESET_PULL(RESET_PULL)) u_state (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rise_i  (rise_all),
    .ready_i (setup_ready),
    .mode_i  (ctrl_q),
    .state_o (pull_state)
  );

  // Read path: control and clock registers only, pin state stays hidden.
  logic [BUS_W-1:0] rd_next, rdata_q, rdata_d;

  always_comb begin
    rd_next = '0;
    if (ctrl_hit) rd_next = {{(BUS_W-2){1'b0}}, ctrl_q};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_next = bank_word[b];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_next;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && !ctrl_hit && (bank_hit == '0)) |=> (bus_rdata == '0));
  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_wr |=> (ctrl_q == $past(bus_wdata[1:0])));

endmodule

// File: tb/pin_pull_sequencer_bench.sv
module pin_pull_sequencer_bench;
  localparam int         NP    = 54;
  localparam int         SETUP = 150;
  localparam int         NB    = 2;
  localparam logic [1:0] RST_PULL = 2'd1;
  localparam logic [7:0] A_CTRL = 8'h94;
  localparam logic [7:0] A_CLK0 = 8'h98;
  localparam logic [7:0] A_CLK1 = 8'h9C;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2*NP-1:0] pull_state;

  always #5 clk = ~clk;

  pin_pull_sequencer #(.NUM_PINS(NP), .SETUP_CYCLES(SETUP), .ADDR_W(8), .RESET_PULL(RST_PULL))
  u_pin_pull_sequencer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_state(pull_state)
  );

  typedef struct {
    string           req;
    bit              is_rd;
    logic [2*NP-1:0] exp_pull;
    logic [31:0]     exp_rd;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    total = 0;
  int    bad   = 0;

  // Reference model of the handshake
  logic [1:0]  m_ctrl;
  logic [31:0] m_clk [NB];
  logic [1:0]  m_pull [NP];
  int          edge_no;
  int          ctrl_edge;

  function automatic logic [31:0] lane_mask(input int b);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (32*b + i < NP) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [2*NP-1:0] model_vec();
    logic [2*NP-1:0] v;
    for (int p = 0; p < NP; p++) v[2*p +: 2] = m_pull[p];
    return v;
  endfunction

  // Monitor: pops expected items and compares at the sampling point
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (it.is_rd) begin
          if (bus_rdata !== it.exp_rd) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", it.req, bus_rdata, it.exp_rd);
          end
        end else if (pull_state !== it.exp_pull) begin
          bad++;
          $display("FAIL %s pull_state actual=%h expected=%h", it.req, pull_state, it.exp_pull);
        end
      end
    end
  end

  // Driver tasks: called at a falling edge, return at a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    edge_no++;
    if (a == A_CTRL) begin
      m_ctrl = d[1:0];
      ctrl_edge = edge_no;
    end
    for (int b = 0; b < NB; b++) begin
      if (a == 8'(A_CLK0 + 4*b)) begin
        for (int i = 0; i < 32; i++) begin
          if (32*b + i < NP && d[i] && !m_clk[b][i] && (edge_no - ctrl_edge >= SETUP))
            m_pull[32*b + i] = (m_ctrl == 2'd3) ? 2'd0 : m_ctrl;
        end
        m_clk[b] = d & lane_mask(b);
      end
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int n = 0; n < k; n++) begin
      @(posedge clk);
      edge_no++;
      @(negedge clk);
    end
  endtask

  task automatic chk_pull(input string req);
    item_t it;
    it.req = req; it.is_rd = 1'b0; it.exp_pull = model_vec(); it.exp_rd = '0;
    sb_q.push_back(it);
    ->chk_ev;
  endtask

  task automatic bus_read(input logic [7:0] a, input string req);
    item_t it;
    logic [31:0] e = '0;
    if (a == A_CTRL) e = {30'd0, m_ctrl};
    for (int b = 0; b < NB; b++) if (a == 8'(A_CLK0 + 4*b)) e = m_clk[b];
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    edge_no++;
    @(negedge clk);
    bus_rd = 1'b0;
    it.req = req; it.is_rd = 1'b1; it.exp_pull = '0; it.exp_rd = e;
    sb_q.push_back(it);
    ->chk_ev;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1..all actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ctrl = 2'd0; edge_no = 0; ctrl_edge = -100000;
    for (int b = 0; b < NB; b++) m_clk[b] = '0;
    for (int p = 0; p < NP; p++) m_pull[p] = RST_PULL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset values
    chk_pull("R1");
    bus_read(A_CTRL, "R1");
    bus_read(A_CLK0, "R1");
    bus_read(A_CLK1, "R1");

    // R2: control storage and readback
    bus_write(A_CTRL, 32'h0000_0002);
    bus_read(A_CTRL, "R2");
    bus_write(A_CTRL, 32'hFFFF_FFF6);
    bus_read(A_CTRL, "R2");

    // R4/R8: latch exactly at the setup boundary, two pins together
    bus_write(A_CTRL, 32'h2);
    idle(SETUP - 1);
    bus_write(A_CLK0, 32'h0000_0220);
    chk_pull("R4");
    bus_read(A_CLK0, "R3");

    // R8: bits 5,9 already high stay, bit 7 rises
    bus_write(A_CTRL, 32'h1);
    idle(SETUP - 1);
    bus_write(A_CLK0, 32'h0000_02A0);
    chk_pull("R8");

    // R9: falling clock bits do nothing
    bus_write(A_CLK0, 32'h0);
    chk_pull("R9");

    // R5: one edge early, then held high
    bus_write(A_CTRL, 32'h0);
    idle(SETUP - 2);
    bus_write(A_CLK0, 32'h0000_0020);
    chk_pull("R5");
    idle(200);
    chk_pull("R5");
    bus_write(A_CLK0, 32'h0);
    bus_write(A_CLK0, 32'h0000_0020);
    chk_pull("R4");

    // R6: rewriting the same value restarts the interval
    bus_write(A_CTRL, 32'h2);
    idle(100);
    bus_write(A_CTRL, 32'h2);
    idle(100);
    bus_write(A_CLK1, 32'h1);
    chk_pull("R6");
    idle(60);
    bus_write(A_CLK1, 32'h0);
    bus_write(A_CLK1, 32'h1);
    chk_pull("R6");

    // R7: reserved code applies as off; R3 upper bits read zero
    bus_write(A_CLK1, 32'h0);
    bus_write(A_CTRL, 32'h3);
    idle(SETUP - 1);
    bus_write(A_CLK1, 32'hFFFF_FFFF);
    chk_pull("R7");
    bus_read(A_CLK1, "R3");
    bus_read(A_CTRL, "R2");

    // R9: unmapped reads return zero and change nothing
    bus_read(8'h00, "R9");
    bus_read(8'h90, "R9");
    bus_read(8'hA0, "R9");
    chk_pull("R9");

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule